// File: doc/BRIEF.md
# Bus Ownership Handoff Controller

This block sits beside a processor's local bus engine and decides when the system bus may be handed to an external DMA master. The external master pulls a request line low. The controller waits until the local engine has no bus cycle in flight, then drives a grant line low. The master answers on a separate acknowledge line. Once that acknowledge is seen, the controller takes the grant away again and keeps the processor's address, data and control drivers switched off. Ownership stays outside for as long as either the request or the acknowledge line is held low.

When both lines have returned high, the controller keeps the drivers off for a programmable number of idle clocks and then hands the bus back to the local engine. If the requester withdraws before it acknowledges, the grant is removed and the processor keeps the bus. Both external inputs are asynchronous to the local clock and pass through a synchronizer of configurable depth. A hold output tells the local engine not to start new cycles while a handoff is pending or in force.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: After reset, bg_no=1, drv_en_o=1, bus_hold_o=0 and state_o=2'b00 (owned).
- R2: A low on br_ni while cycle_busy_i=0 drives bg_no=0, bus_hold_o=1 and state_o=2'b01 (granting) on the (SYNC_STAGES+1)-th rising edge after the change. Before that edge the outputs are unchanged.
- R3: While cycle_busy_i=1 no grant is issued, even with br_ni low. The grant appears on the first rising edge after cycle_busy_i falls.
- R4: A low on bgack_ni while granting gives bg_no=1, drv_en_o=0 and state_o=2'b10 (released) on the (SYNC_STAGES+1)-th rising edge.
- R5: If br_ni returns high while granting and bgack_ni stays high, the block returns to owned after SYNC_STAGES+1 edges, with bg_no=1, drv_en_o=1 and bus_hold_o=0.
- R6: While released, a low on either br_ni or bgack_ni keeps state_o=2'b10 and drv_en_o=0.
- R7: Once both br_ni and bgack_ni are seen high while released, drivers stay off (state_o=2'b10, bus_hold_o=1) for IDLE_CYCLES clocks, and then the block returns to owned with drv_en_o=1.
- R8: If the acknowledge arrives in the same synchronized sample as the withdrawal of the request, the acknowledge wins and the block goes to released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_ni | input | 1 | External bus request, active low, asynchronous |
| bgack_ni | input | 1 | External mastership acknowledge, active low, asynchronous |
| cycle_busy_i | input | 1 | Local bus engine has a cycle in flight |
| bg_no | output | 1 | Bus grant, active low |
| drv_en_o | output | 1 | Enable for the local address, data and control drivers |
| bus_hold_o | output | 1 | Local engine must not start a new cycle |
| state_o | output | 2 | 00 owned, 01 granting, 10 released |

## Verification
Two events can fall in the same synchronized sample: the requester withdrawing and the acknowledge arriving. The bench provokes this by changing br_ni and bgack_ni at the same falling edge while the block is granting. It then checks that the block goes to released, not owned, and that drivers stay off until both lines are high. A second pairing occurs when the busy indication falls while a request is already pending. Here the bench checks that the grant appears exactly one edge later.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;
  typedef enum logic [1:0] {
    ST_OWNED   = 2'b00,
    ST_GRANT   = 2'b01,
    ST_EXT     = 2'b10,
    ST_RECLAIM = 2'b11
  } arb_state_e;

  localparam logic [1:0] RPT_OWNED    = 2'b00;
  localparam logic [1:0] RPT_GRANTING = 2'b01;
  localparam logic [1:0] RPT_RELEASED = 2'b10;
endpackage

// File: rtl/handoff_sync.sv
module handoff_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/handoff_fsm.sv
module handoff_fsm
  import bus_handoff_pkg::*;
#(
  parameter int IDLE_CYCLES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       busy_i,
  output logic       grant_o,
  output logic       drv_en_o,
  output logic       hold_o,
  output logic [1:0] state_o
);
  localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYCLES - 1);

  arb_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OWNED:   if (req_i && !busy_i) state_d = ST_GRANT;
      // acknowledge outranks a simultaneous withdrawal
      ST_GRANT:   if (ack_i) state_d = ST_EXT;
                  else if (!req_i) state_d = ST_OWNED;
      ST_EXT: begin
        cnt_d = '0;
        if (!req_i && !ack_i) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (cnt_q == CNT_LAST) state_d = ST_OWNED;
        else cnt_d = cnt_q + 1'b1;
      end
      default:    state_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OWNED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign grant_o  = (state_q == ST_GRANT);
  assign drv_en_o = (state_q == ST_OWNED) || (state_q == ST_GRANT);
  assign hold_o   = (state_q != ST_OWNED);
  always_comb begin
    unique case (state_q)
      ST_OWNED: state_o = RPT_OWNED;
      ST_GRANT: state_o = RPT_GRANTING;
      default:  state_o = RPT_RELEASED;
    endcase
  end

  a_r3_grant_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(!busy_i));
  a_r4_grant_drops_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(grant_o) && $past(ack_i)) |-> (!grant_o && !drv_en_o));
  a_r5_abort_keeps_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(grant_o) && $past(!req_i && !ack_i)) |-> (drv_en_o && !grant_o));
  a_r6_no_grant_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && !drv_en_o));
  a_r7_reclaim_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(state_q == ST_RECLAIM));
  a_r6_stay_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == ST_EXT) && $past(req_i || ack_i)) |-> !drv_en_o);
endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       br_ni,
  input  logic       bgack_ni,
  input  logic       cycle_busy_i,
  output logic       bg_no,
  output logic       drv_en_o,
  output logic       bus_hold_o,
  output logic [1:0] state_o
);
  logic req_s, ack_s, grant;

  handoff_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(~br_ni), .q_o(req_s));
  handoff_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(~bgack_ni), .q_o(ack_s));

  handoff_fsm #(.IDLE_CYCLES(IDLE_CYCLES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_s),
    .ack_i   (ack_s),
    .busy_i  (cycle_busy_i),
    .grant_o (grant),
    .drv_en_o(drv_en_o),
    .hold_o  (bus_hold_o),
    .state_o (state_o)
  );

  assign bg_no = ~grant;

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (bg_no && drv_en_o));
endmodule

// File: tb/bus_handoff_ctrl_tb.sv
module bus_handoff_ctrl_tb;
  localparam int LAT = 3; // SYNC_STAGES + 1

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic br_ni = 1'b1, bgack_ni = 1'b1, busy = 1'b0;
  logic bg_no, drv_en, hold;
  logic [1:0] st;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bus_handoff_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .br_ni(br_ni), .bgack_ni(bgack_ni),
    .cycle_busy_i(busy), .bg_no(bg_no), .drv_en_o(drv_en),
    .bus_hold_o(hold), .state_o(st));

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic e_bg, input logic e_drv,
                            input logic e_hold, input logic [1:0] e_st);
    n_chk++;
    if (bg_no !== e_bg || drv_en !== e_drv || hold !== e_hold || st !== e_st) begin
      n_bad++;
      $display("FAIL %s: got bg=%b drv=%b hold=%b st=%b exp bg=%b drv=%b hold=%b st=%b",
               req, bg_no, drv_en, hold, st, e_bg, e_drv, e_hold, e_st);
    end
  endtask

  task automatic t_reset;
    expect_out("R1", 1, 1, 0, 2'b00);
  endtask

  task automatic t_grant_abort;
    br_ni = 0;
    edges(LAT - 1);
    expect_out("R2 early", 1, 1, 0, 2'b00);
    edges(1);
    expect_out("R2", 0, 1, 1, 2'b01);
    br_ni = 1;
    edges(LAT - 1);
    expect_out("R5 early", 0, 1, 1, 2'b01);
    edges(1);
    expect_out("R5", 1, 1, 0, 2'b00);
  endtask

  task automatic t_busy_defer;
    busy = 1; br_ni = 0;
    edges(LAT + 3);
    expect_out("R3 held", 1, 1, 0, 2'b00);
    busy = 0;
    edges(1);
    expect_out("R3", 0, 1, 1, 2'b01);
    br_ni = 1;
    edges(LAT);
    expect_out("R5 after R3", 1, 1, 0, 2'b00);
  endtask

  task automatic t_transfer;
    br_ni = 0;
    edges(LAT);
    expect_out("R2 xfer", 0, 1, 1, 2'b01);
    bgack_ni = 0;
    edges(LAT);
    expect_out("R4", 1, 0, 1, 2'b10);
    bgack_ni = 1;
    edges(LAT + 2);
    expect_out("R6 br low", 1, 0, 1, 2'b10);
    br_ni = 1;
    edges(LAT);
    expect_out("R7 idle", 1, 0, 1, 2'b10);
    edges(1);
    expect_out("R7", 1, 1, 0, 2'b00);
  endtask

  task automatic t_same_sample;
    br_ni = 0;
    edges(LAT);
    expect_out("R2 race", 0, 1, 1, 2'b01);
    br_ni = 1; bgack_ni = 0;
    edges(LAT);
    expect_out("R8", 1, 0, 1, 2'b10);
    edges(LAT + 2);
    expect_out("R6 ack low", 1, 0, 1, 2'b10);
    bgack_ni = 1;
    edges(LAT);
    expect_out("R7 race idle", 1, 0, 1, 2'b10);
    edges(1);
    expect_out("R7 race", 1, 1, 0, 2'b00);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    edges(1);
    t_reset();
    t_grant_abort();
    t_busy_defer();
    t_transfer();
    t_same_sample();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule